// File: doc/BRIEF.md
# Memory request and refresh arbiter

This block decides who gets the next memory timing sequence: the bus requester or the periodic DRAM refresh. It issues one-clock start pulses to a separate timing sequencer. It watches the sequencer's busy and done indications so that it never starts a sequence on top of a running one. An internal down-counter raises a refresh-ready flag at a fixed interval. The flag stays up until a refresh is granted.

Refresh normally has the lowest priority, but the order in which requests arrive is respected. A refresh that became ready on an earlier clock than the bus request wins. One that became ready on the same clock as the request, or later, waits until no bus request is pending.

A bus cycle may be a page burst. When the sequencer reports done and the requester still holds the page input, the arbiter restarts the sequencer at once, with no new arbitration. If the requester drops the page input before that done, the burst ends there and the next requester can be served straight away.

Top module: `memreq_arbiter`

## Requirements
- R1: While `rst` is high (synchronous, active high) and in the first cycle after it falls, `go_mem`, `bus_ack`, `go_ref`, `page_again` and `ref_ready` are all 0.
- R2: `ref_ready` rises in the cycle numbered k*REFRESH_INTERVAL (k = 1, 2, ...), where cycle 0 is the first cycle with `rst` low. It stays high until a refresh is granted.
- R3: In the cycle in which `go_ref` is high, `ref_ready` is 0, unless a new interval ends at that same edge. `go_ref` is only issued when `ref_ready` was high in the cycle before.
- R4: If `ref_ready` became high on a clock strictly before the clock on which the pending `bus_req` rose, the refresh is started first.
- R5: If `ref_ready` became high on the same clock as the pending `bus_req` or later, the bus request is started first. The refresh waits until `bus_req` is low.
- R6: A bus cycle is granted when the arbiter is free and `bus_req` is high. `go_mem` and `bus_ack` then go high together for exactly one clock, in the cycle after the deciding cycle.
- R7: If `seq_busy` is high in a cycle, neither `go_mem` nor `go_ref` is high in the next cycle.
- R8: A refresh holds the arbiter for REF_CLOCKS clocks. In the REF_CLOCKS-1 cycles after `go_ref`, none of `go_mem`, `go_ref` or `page_again` is issued.
- R9: During a page burst (`page_hold` was high in the deciding cycle), a cycle with both `seq_done` and `page_hold` high is followed by a one-clock `page_again` pulse. No new arbitration takes place.
- R10: A `seq_done` in a bus cycle with `page_hold` low ends the bus cycle. The arbiter is free in the next cycle, so a start can appear two cycles after `seq_done`.
- R11: At most one of `go_mem`, `go_ref` and `page_again` is high in any cycle.
- R12: While a bus cycle is outstanding (from the grant until its final `seq_done`), a high `bus_req` does not produce another `go_mem`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus memory request, held high until `bus_ack` |
| page_hold | input | 1 | Page-mode hold from the requester |
| seq_busy | input | 1 | Timing sequencer is running |
| seq_done | input | 1 | Sequencer finishes its current sequence this cycle |
| go_mem | output | 1 | One-clock start of a bus memory sequence |
| bus_ack | output | 1 | One-clock acknowledgement to the bus requester |
| go_ref | output | 1 | One-clock refresh grant and start |
| page_again | output | 1 | One-clock restart of a page-repeat sequence |
| ref_ready | output | 1 | Refresh is due and not yet granted |

## Verification
Every start pulse, and the clearing of `ref_ready`, appears in the cycle after the deciding cycle. `ref_ready` rises exactly at the interval boundaries. After a `go_ref`, no start may appear for REF_CLOCKS-1 cycles. `page_again` follows its `seq_done` by one cycle.

The bench works on the falling edge. There it compares the outputs with the values it predicted one cycle earlier, then drives the inputs for that cycle. After that it predicts the next cycle's outputs from the arrival cycles of the requests and from the ownership windows, which it tracks as integers. Directed arrivals place a refresh before, at and after a bus request, and run a two-repeat page burst. A pseudo-random phase with extra sequencer-busy windows follows.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_BUS  = 2'd1,
    OWN_REF  = 2'd2
  } owner_t;
endpackage

// File: rtl/refresh_timer.sv
module refresh_timer #(
  parameter int INTERVAL = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic grant,
  output logic ready
);
  localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= RELOAD;
      ready <= 1'b0;
    end else begin
      cnt <= tick ? RELOAD : cnt - 1'b1;
      // a new interval end wins over the clearing grant
      if (tick)       ready <= 1'b1;
      else if (grant) ready <= 1'b0;
    end
  end
endmodule

// File: rtl/order_tracker.sv
module order_tracker (
  input  logic clk,
  input  logic rst,
  input  logic ref_ready,
  input  logic bus_req,
  input  logic ref_take,
  output logic ref_first
);
  // sticky: refresh was seen ready while no bus request was up
  always_ff @(posedge clk) begin
    if (rst)                         ref_first <= 1'b0;
    else if (ref_take)               ref_first <= 1'b0;
    else if (ref_ready && !bus_req)  ref_first <= 1'b1;
  end
endmodule

// File: rtl/arb_core.sv
module arb_core
  import arb_pkg::*;
#(
  parameter int REF_CLOCKS = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_req,
  input  logic page_hold,
  input  logic seq_busy,
  input  logic seq_done,
  input  logic ref_ready,
  input  logic ref_first,
  output logic ref_take,
  output logic go_mem,
  output logic bus_ack,
  output logic go_ref,
  output logic page_again
);
  localparam int RCW = $clog2(REF_CLOCKS + 1);
  localparam logic [RCW-1:0] HOLD_LOAD = RCW'(REF_CLOCKS - 1);

  owner_t         owner;
  logic           paging;
  logic [RCW-1:0] hold_cnt;
  logic           free, pick_ref, pick_bus, cont_page, end_bus;

  always_comb begin
    free      = !seq_busy &&
                ((owner == OWN_NONE) || (owner == OWN_REF && hold_cnt == '0));
    pick_ref  = free && ref_ready && (ref_first || !bus_req);
    pick_bus  = free && bus_req && !pick_ref;
    cont_page = (owner == OWN_BUS) && paging && seq_done && page_hold;
    end_bus   = (owner == OWN_BUS) && seq_done && !cont_page;
  end

  assign ref_take = pick_ref;

  always_ff @(posedge clk) begin
    if (rst) begin
      owner      <= OWN_NONE;
      paging     <= 1'b0;
      hold_cnt   <= '0;
      go_mem     <= 1'b0;
      bus_ack    <= 1'b0;
      go_ref     <= 1'b0;
      page_again <= 1'b0;
    end else begin
      go_mem     <= pick_bus;
      bus_ack    <= pick_bus;
      go_ref     <= pick_ref;
      page_again <= cont_page;
      if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
      if (pick_ref) begin
        owner    <= OWN_REF;
        hold_cnt <= HOLD_LOAD;
        paging   <= 1'b0;
      end else if (pick_bus) begin
        owner  <= OWN_BUS;
        paging <= page_hold;
      end else if (end_bus) begin
        owner  <= OWN_NONE;
        paging <= 1'b0;
      end else if (owner == OWN_REF && hold_cnt == '0) begin
        owner <= OWN_NONE;
      end
    end
  end
endmodule

// File: rtl/memreq_arbiter.sv
module memreq_arbiter #(
  parameter int REFRESH_INTERVAL = 64,
  parameter int REF_CLOCKS       = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_req,
  input  logic page_hold,
  input  logic seq_busy,
  input  logic seq_done,
  output logic go_mem,
  output logic bus_ack,
  output logic go_ref,
  output logic page_again,
  output logic ref_ready
);
  logic ref_take;
  logic ref_first;

  refresh_timer #(.INTERVAL(REFRESH_INTERVAL)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .grant (ref_take),
    .ready (ref_ready)
  );

  order_tracker u_order (
    .clk       (clk),
    .rst       (rst),
    .ref_ready (ref_ready),
    .bus_req   (bus_req),
    .ref_take  (ref_take),
    .ref_first (ref_first)
  );

  arb_core #(.REF_CLOCKS(REF_CLOCKS)) u_core (
    .clk        (clk),
    .rst        (rst),
    .bus_req    (bus_req),
    .page_hold  (page_hold),
    .seq_busy   (seq_busy),
    .seq_done   (seq_done),
    .ref_ready  (ref_ready),
    .ref_first  (ref_first),
    .ref_take   (ref_take),
    .go_mem     (go_mem),
    .bus_ack    (bus_ack),
    .go_ref     (go_ref),
    .page_again (page_again)
  );
endmodule

// File: rtl/memreq_arbiter_chk.sv
module memreq_arbiter_chk #(
  parameter int REF_CLOCKS = 5
) (
  input logic clk,
  input logic rst,
  input logic bus_req,
  input logic page_hold,
  input logic seq_busy,
  input logic seq_done,
  input logic go_mem,
  input logic bus_ack,
  input logic go_ref,
  input logic page_again,
  input logic ref_ready
);
  localparam int GW = $clog2(REF_CLOCKS + 1);
  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst)                          gap <= GW'(REF_CLOCKS);
    else if (go_ref)                  gap <= GW'(1);
    else if (gap < GW'(REF_CLOCKS))   gap <= gap + 1'b1;
  end

  p_ref_from_ready_r3: assert property (@(posedge clk) disable iff (rst)
    go_ref |-> $past(ref_ready));

  p_ack_needs_req_r6: assert property (@(posedge clk) disable iff (rst)
    bus_ack |-> $past(bus_req));

  p_go_one_clock_r6: assert property (@(posedge clk) disable iff (rst)
    go_mem |=> !go_mem);

  p_busy_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    $past(seq_busy) |-> !(go_mem || go_ref));

  p_ref_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (go_mem || go_ref || page_again) |-> (gap >= GW'(REF_CLOCKS)));

  p_page_again_r9: assert property (@(posedge clk) disable iff (rst)
    page_again |-> $past(seq_done && page_hold));

  p_starts_exclusive_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({go_mem, go_ref, page_again}));
endmodule

bind memreq_arbiter memreq_arbiter_chk #(.REF_CLOCKS(REF_CLOCKS)) u_chk (.*);

// File: tb/memreq_arbiter_test.sv
`timescale 1ns/1ps
module memreq_arbiter_test;
  localparam int INTERVAL = 40;
  localparam int REFC     = 5;
  localparam int BUSY_LEN = 6;
  localparam int NCYC     = 3000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_req = 1'b0, page_hold = 1'b0, seq_busy = 1'b0, seq_done = 1'b0;
  logic go_mem, bus_ack, go_ref, page_again, ref_ready;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  memreq_arbiter #(.REFRESH_INTERVAL(INTERVAL), .REF_CLOCKS(REFC)) uut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .page_hold(page_hold),
    .seq_busy(seq_busy), .seq_done(seq_done), .go_mem(go_mem),
    .bus_ack(bus_ack), .go_ref(go_ref), .page_again(page_again),
    .ref_ready(ref_ready)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp, input int cyc);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not end)");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // expectations for the current cycle
    bit e_go = 0, e_ack = 0, e_ref = 0, e_page = 0, e_ready = 0;
    // model state
    bit m_ready = 0, m_paging = 0, prev_req = 0, prev_busy = 0;
    int m_owner = 0, m_ref_free = 0, m_ra = 0, m_ba = 0;
    int last_ref = -100, last_end = -100;
    int r4_ev = 0, r5_ev = 0, r9_ev = 0, r10_ev = 0, r12_ev = 0;
    bit owned_req = 0;
    // stimulus state
    int seq_rem = 0, want = 0, seen = 0;
    int unsigned lcg = 32'h1234_5678;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    for (int c = 0; c < NCYC; c++) begin
      bit free, ref_wins, pick_ref, pick_bus, cont, endb, fire, dropped;
      if (c > 0) @(negedge clk);

      // ---- compare outputs of cycle c ----
      if (c == 0) begin
        chk(!go_mem && !bus_ack && !go_ref && !page_again && !ref_ready, "R1 reset outputs",
            {go_mem, bus_ack, go_ref, page_again, ref_ready}, 0, c);
      end
      chk(go_mem == e_go, "R6 go_mem", go_mem, e_go, c);
      chk(bus_ack == e_ack, "R6 bus_ack", bus_ack, e_ack, c);
      chk(go_ref == e_ref, "R4 go_ref order", go_ref, e_ref, c);
      chk(page_again == e_page, "R9 page_again", page_again, e_page, c);
      chk(ref_ready == e_ready, "R2 ref_ready", ref_ready, e_ready, c);
      chk((go_mem + go_ref + page_again) <= 1, "R11 exclusive starts",
          go_mem + go_ref + page_again, 1, c);
      if (go_ref && (c % INTERVAL) != 0)
        chk(!ref_ready, "R3 ready cleared on grant", ref_ready, 0, c);
      if (prev_busy)
        chk(!go_mem && !go_ref, "R7 start while busy", go_mem | go_ref, 0, c);
      if (c - last_ref >= 1 && c - last_ref <= REFC - 1)
        chk(!go_mem && !go_ref && !page_again, "R8 refresh hold", go_mem | go_ref | page_again, 0, c);
      if (owned_req) begin
        chk(!go_mem, "R12 no regrant while owned", go_mem, 0, c);
        r12_ev++;
      end
      if (go_ref) last_ref = c;
      if (page_again) r9_ev++;

      // ---- drive inputs of cycle c ----
      lcg = lcg * 32'd1103515245 + 32'd12345;
      if (seq_rem == 0 && m_owner != 1 && c >= 205 && ((lcg >> 20) % 20) == 0) seq_rem = 4;
      seq_busy = (seq_rem > 0);
      seq_done = (seq_rem == 1);
      if (seq_rem > 0) seq_rem--;
      if (go_mem || page_again) seq_rem = BUSY_LEN;

      dropped = 0;
      if (bus_ack) begin
        bus_req = 1'b0;
        dropped = 1;
        if (want == 0) page_hold = 1'b0;
      end
      if (page_again) begin
        seen++;
        if (seen >= want) page_hold = 1'b0;
      end
      if (!bus_req && !dropped && !page_hold) begin
        if (c == 40 || c == 75 || c == 81 || c == 112 || c == 120 || c == 189) begin
          bus_req = 1'b1; want = 0;
        end else if (c == 170) begin
          bus_req = 1'b1; page_hold = 1'b1; want = 2; seen = 0;
        end else if (c >= 205 && ((lcg >> 16) % 7) == 0) begin
          bus_req = 1'b1; want = 0;
          if (((lcg >> 8) % 3) == 0 && m_owner != 1) begin
            page_hold = 1'b1; want = int'((lcg >> 4) % 3); seen = 0;
          end
        end
      end

      // ---- model: predict cycle c+1 ----
      if (bus_req && !prev_req) m_ba = c;
      prev_req  = bus_req;
      prev_busy = seq_busy;
      free     = !seq_busy && (m_owner == 0 || (m_owner == 2 && c >= m_ref_free));
      ref_wins = m_ready && (!bus_req || m_ra < m_ba);
      pick_ref = free && ref_wins;
      pick_bus = free && bus_req && !pick_ref;
      cont     = (m_owner == 1) && m_paging && seq_done && page_hold;
      endb     = (m_owner == 1) && seq_done && !cont;
      owned_req = (m_owner == 1) && bus_req;
      if (pick_ref && bus_req) r4_ev++;
      if (pick_bus && m_ready) r5_ev++;
      if ((pick_bus || pick_ref) && last_end == c - 1) r10_ev++;

      fire = ((c + 1) % INTERVAL) == 0;
      if (fire && (!m_ready || pick_ref)) m_ra = c + 1;
      e_ready = fire ? 1'b1 : (pick_ref ? 1'b0 : m_ready);
      m_ready = e_ready;
      e_go = pick_bus; e_ack = pick_bus; e_ref = pick_ref; e_page = cont;

      if (pick_ref) begin
        m_owner = 2; m_ref_free = c + REFC; m_paging = 0;
      end else if (pick_bus) begin
        m_owner = 1; m_paging = page_hold;
      end else if (endb) begin
        m_owner = 0; m_paging = 0; last_end = c;
      end
    end

    chk(r4_ev > 0, "R4 earlier refresh won over a bus request", r4_ev, 1, NCYC);
    chk(r5_ev > 0, "R5 bus request won over a same-clock or later refresh", r5_ev, 1, NCYC);
    chk(r9_ev >= 2, "R9 page repeats seen", r9_ev, 2, NCYC);
    chk(r10_ev > 0, "R10 start right after a burst ended", r10_ev, 1, NCYC);
    chk(r12_ev > 0, "R12 request raised during an owned cycle", r12_ev, 1, NCYC);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule